// File: doc/BRIEF.md
# Delayed Branch Sequencer

This unit generates the fetch address for an eight-stage in-order pipeline (two fetch stages, two decode stages, two read stages, execute, write back). The surrounding decoder presents the decoded kind, condition code and target of the instruction in the second decode stage. The unit tracks which stages hold live instructions, and it evaluates each branch, call or return against the zero, negative and test flags at that decode point. It carries the decision down the pipe and changes the fetch address only when the instruction arrives in execute. Because of this, the three instructions that follow a control transfer always run, and the three fetched after them are discarded.

A single return register holds the resume point for one call level. A separate write port lets a stored copy be restored, which is how deeper nesting is handled. A stop instruction that reaches execute ends the task: fetching stops and a one-cycle completion pulse is raised. The unit also checks that no two control instructions (branch, call, return, stop, debug stop) sit within three issue positions of each other, and it raises an error pulse when they do. A stall input freezes the whole pipe during memory conflicts.

Top module: `branch_sequencer`

## Requirements
- R1: After reset, fetchEn, decValid, running, taskDone and slotErr are 0 and retAddr is 0.
- R2: When taskGo is high, running is 0 and stall is low, the next fetch address is taskVec. Fetch then proceeds at +1 per unstalled cycle. taskGo has no effect while running is 1.
- R3: The condition code on decCond is tested with the flags present while the instruction is in the decode stage (the cycle it leaves decode): 0 always, 1 zero set, 2 zero clear, 3 negative set, 4 negative clear, 5 zero and negative both clear, 6 zero or negative set, 7 test set, 8 test clear; codes 9 to 15 are never true.
- R4: A taken branch (decOp 1) at address B fetches B+1..B+6 and then decTarget. Only B+1..B+3 reach decode as valid; B+4..B+6 are squashed and have no effect, even when they are stop instructions.
- R5: A taken call (decOp 2) at address C redirects like a branch and sets retAddr to C+4. A taken return (decOp 3) redirects fetch to retAddr.
- R6: A one-cycle retWrEn loads retWrData into retAddr. retAddr holds when it is neither written nor saved by a call.
- R7: A stop (decOp 4) at address S fetches through S+6, then fetching ends. taskDone pulses for one cycle and running drops. A debug stop (decOp 5) acts as no operation for fetching.
- R8: While stall is high, no stage advances: fetchAddr, fetchEn, decValid and running are frozen, and a stalled run yields the same fetch sequence as an unstalled one.
- R9: When a valid control instruction (decOp 1 to 5) leaves decode while a valid control instruction sits in any of the three stages after it, slotErr pulses in the next cycle. Instructions four or more positions apart, and squashed instructions, raise no error.
- R10: A branch, call or return whose condition is false does not redirect, and a false call leaves retAddr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Memory-conflict stall; freezes all stages |
| taskGo | input | 1 | Start request while idle |
| taskVec | input | ADDR_W | Start address of the task |
| decOp | input | 3 | Kind of the decode-stage instruction: 0 other, 1 branch, 2 call, 3 return, 4 stop, 5 debug stop |
| decCond | input | 4 | Condition code of the decode-stage instruction |
| decTarget | input | ADDR_W | Branch or call target of the decode-stage instruction |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagT | input | 1 | Test flag |
| retWrEn | input | 1 | Restore strobe for the return register |
| retWrData | input | ADDR_W | Value restored into the return register |
| fetchAddr | output | ADDR_W | Address in the first fetch stage |
| fetchEn | output | 1 | First fetch stage holds a live fetch |
| decPc | output | ADDR_W | Address of the instruction in the decode stage |
| decValid | output | 1 | Decode stage holds a live instruction |
| retAddr | output | ADDR_W | Return register |
| running | output | 1 | A task is being fetched |
| taskDone | output | 1 | One-cycle pulse when a stop reaches execute |
| slotErr | output | 1 | One-cycle pulse on a delay-slot violation |

## Verification
The assertions assume three things about the inputs. The decode inputs describe the instruction at decPc whenever decValid is high. taskGo is raised only in cycles without stall. A return-register restore never coincides with a call in execute. The bench drives decode fields combinationally from its own program table, indexed by the decode-stage address. It starts tasks only after holding stall low for two cycles, and it restores the return register only while idle. It also changes the flags only at the instant a chosen branch sits in decode, so the effect of any later flag change can be seen. Legal programs keep control instructions at least four positions apart; violations are placed only in the runs that check the error pulse, where the fetch comparison is turned off.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_BRANCH  = 3'd1,
    OP_CALL    = 3'd2,
    OP_RETURN  = 3'd3,
    OP_STOP    = 3'd4,
    OP_DBGSTOP = 3'd5
  } opKind_e;

  localparam int COND_W = 4;

  // condition codes
  localparam logic [COND_W-1:0] CC_ALWAYS = 4'd0;
  localparam logic [COND_W-1:0] CC_ZSET   = 4'd1;
  localparam logic [COND_W-1:0] CC_ZCLR   = 4'd2;
  localparam logic [COND_W-1:0] CC_NSET   = 4'd3;
  localparam logic [COND_W-1:0] CC_NCLR   = 4'd4;
  localparam logic [COND_W-1:0] CC_POS    = 4'd5;
  localparam logic [COND_W-1:0] CC_NPOS   = 4'd6;
  localparam logic [COND_W-1:0] CC_TSET   = 4'd7;
  localparam logic [COND_W-1:0] CC_TCLR   = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic pcStep;
    logic loadVector;
    logic jumpTarget;
    logic jumpReturn;
    logic saveReturn;
  } seqStrobe_t;

  function automatic logic isFlowCtl(opKind_e op);
    return (op == OP_BRANCH) || (op == OP_CALL) || (op == OP_RETURN) ||
           (op == OP_STOP)   || (op == OP_DBGSTOP);
  endfunction

  function automatic logic isTransfer(opKind_e op);
    return (op == OP_BRANCH) || (op == OP_CALL) || (op == OP_RETURN);
  endfunction

  function automatic logic condMet(logic [COND_W-1:0] cc, logic z, logic n, logic t);
    logic hit;
    case (cc)
      CC_ALWAYS: hit = 1'b1;
      CC_ZSET:   hit = z;
      CC_ZCLR:   hit = ~z;
      CC_NSET:   hit = n;
      CC_NCLR:   hit = ~n;
      CC_POS:    hit = ~z & ~n;
      CC_NPOS:   hit = z | n;
      CC_TSET:   hit = t;
      CC_TCLR:   hit = ~t;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import flowseq_pkg::*;
#(
  parameter int NUM_STAGES = 7,
  parameter int DEC_IDX    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stall,
  input  logic                 taskGo,
  input  opKind_e              decOp,
  input  logic [COND_W-1:0]    decCond,
  input  logic                 flagZ,
  input  logic                 flagN,
  input  logic                 flagT,
  output seqStrobe_t           strb,
  output logic                 fetchEn,
  output logic                 decValid,
  output logic                 running,
  output logic                 taskDone,
  output logic                 slotErr
);

  localparam int EXE_IDX  = NUM_STAGES - 1;
  localparam int SLOT_CNT = EXE_IDX - DEC_IDX;

  logic [NUM_STAGES-1:0] vld;
  opKind_e               opQ [SLOT_CNT];
  logic [SLOT_CNT-1:0]   takeQ;
  logic [SLOT_CNT-1:0]   priorCtl;

  logic    advance, goAcc, decTake, decCtl;
  logic    exeJump, exeStop, flush;
  opKind_e exeOp;

  assign advance = ~stall;
  assign exeOp   = opQ[SLOT_CNT-1];
  assign goAcc   = taskGo & ~running & advance;
  assign decTake = condMet(decCond, flagZ, flagN, flagT);
  assign decCtl  = vld[DEC_IDX] & isFlowCtl(decOp);
  assign exeJump = vld[EXE_IDX] & running & takeQ[SLOT_CNT-1] & isTransfer(exeOp);
  assign exeStop = vld[EXE_IDX] & running & (exeOp == OP_STOP);
  assign flush   = exeJump | exeStop;

  // live control instructions in the stages behind decode
  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_prior
    assign priorCtl[k] = vld[DEC_IDX+1+k] & isFlowCtl(opQ[k]);
  end

  always_comb begin
    strb            = '0;
    strb.advance    = advance;
    strb.loadVector = goAcc;
    strb.jumpTarget = advance & exeJump & (exeOp != OP_RETURN);
    strb.jumpReturn = advance & exeJump & (exeOp == OP_RETURN);
    strb.saveReturn = advance & exeJump & (exeOp == OP_CALL);
    strb.pcStep     = advance & vld[0] & ~exeJump;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld      <= '0;
      takeQ    <= '0;
      running  <= 1'b0;
      taskDone <= 1'b0;
      slotErr  <= 1'b0;
      for (int k = 0; k < SLOT_CNT; k++) opQ[k] <= OP_NONE;
    end else begin
      taskDone <= advance & exeStop;
      slotErr  <= advance & decCtl & (|priorCtl);
      if (advance) begin
        vld[0] <= goAcc | (running & ~exeStop);
        for (int i = 1; i <= DEC_IDX; i++) vld[i] <= vld[i-1] & ~flush;
        for (int i = DEC_IDX + 1; i < NUM_STAGES; i++) vld[i] <= vld[i-1];
        opQ[0]   <= decOp;
        takeQ[0] <= decTake;
        for (int k = 1; k < SLOT_CNT; k++) begin
          opQ[k]   <= opQ[k-1];
          takeQ[k] <= takeQ[k-1];
        end
        if (goAcc)        running <= 1'b1;
        else if (exeStop) running <= 1'b0;
      end
    end
  end

  assign fetchEn  = vld[0];
  assign decValid = vld[DEC_IDX];

  // R4
  redirect_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadVector, strb.jumpTarget, strb.jumpReturn}));

  // R7
  done_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    taskDone |-> !running);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    taskDone |=> !taskDone);

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(fetchEn) && $stable(decValid) && $stable(running)));

endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import flowseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_STAGES = 7,
  parameter int DEC_IDX    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] taskVec,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              retWrEn,
  input  logic [ADDR_W-1:0] retWrData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] decPc,
  output logic [ADDR_W-1:0] retAddr
);

  localparam int EXE_IDX  = NUM_STAGES - 1;
  localparam int SLOT_CNT = EXE_IDX - DEC_IDX;
  localparam int RET_OFS  = SLOT_CNT + 1;

  logic [ADDR_W-1:0] addrQ [NUM_STAGES];
  logic [ADDR_W-1:0] tgtQ  [SLOT_CNT];
  logic [ADDR_W-1:0] retQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STAGES; i++) addrQ[i] <= '0;
      for (int k = 0; k < SLOT_CNT; k++)   tgtQ[k]  <= '0;
      retQ <= '0;
    end else begin
      if (strb.advance) begin
        for (int i = 1; i < NUM_STAGES; i++) addrQ[i] <= addrQ[i-1];
        tgtQ[0] <= decTarget;
        for (int k = 1; k < SLOT_CNT; k++) tgtQ[k] <= tgtQ[k-1];
        if (strb.loadVector)      addrQ[0] <= taskVec;
        else if (strb.jumpReturn) addrQ[0] <= retQ;
        else if (strb.jumpTarget) addrQ[0] <= tgtQ[SLOT_CNT-1];
        else if (strb.pcStep)     addrQ[0] <= addrQ[0] + 1'b1;
      end
      if (strb.saveReturn) retQ <= addrQ[EXE_IDX] + ADDR_W'(RET_OFS);
      else if (retWrEn)    retQ <= retWrData;
    end
  end

  assign fetchAddr = addrQ[0];
  assign decPc     = addrQ[DEC_IDX];
  assign retAddr   = retQ;

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> ($stable(fetchAddr) && $stable(decPc)));

  // R6
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.saveReturn && !retWrEn) |=> $stable(retAddr));

endmodule

// File: rtl/branch_sequencer.sv
module branch_sequencer
  import flowseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              taskGo,
  input  logic [ADDR_W-1:0] taskVec,
  input  logic [2:0]        decOp,
  input  logic [3:0]        decCond,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagT,
  input  logic              retWrEn,
  input  logic [ADDR_W-1:0] retWrData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchEn,
  output logic [ADDR_W-1:0] decPc,
  output logic              decValid,
  output logic [ADDR_W-1:0] retAddr,
  output logic              running,
  output logic              taskDone,
  output logic              slotErr
);

  localparam int NUM_STAGES = 7;  // two fetch, two decode, two read, execute
  localparam int DEC_IDX    = 3;

  seqStrobe_t strb;

  seq_ctrl #(
    .NUM_STAGES (NUM_STAGES),
    .DEC_IDX    (DEC_IDX)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stall    (stall),
    .taskGo   (taskGo),
    .decOp    (opKind_e'(decOp)),
    .decCond  (decCond),
    .flagZ    (flagZ),
    .flagN    (flagN),
    .flagT    (flagT),
    .strb     (strb),
    .fetchEn  (fetchEn),
    .decValid (decValid),
    .running  (running),
    .taskDone (taskDone),
    .slotErr  (slotErr)
  );

  seq_dpath #(
    .ADDR_W     (ADDR_W),
    .NUM_STAGES (NUM_STAGES),
    .DEC_IDX    (DEC_IDX)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .taskVec   (taskVec),
    .decTarget (decTarget),
    .retWrEn   (retWrEn),
    .retWrData (retWrData),
    .fetchAddr (fetchAddr),
    .decPc     (decPc),
    .retAddr   (retAddr)
  );

endmodule

// File: tb/branch_sequencer_tb.sv
module branch_sequencer_tb;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stall = 1'b0;
  logic          taskGo = 1'b0;
  logic [AW-1:0] taskVec = '0;
  logic [2:0]    decOp;
  logic [3:0]    decCond;
  logic [AW-1:0] decTarget;
  logic          flagZ, flagN, flagT;
  logic          retWrEn = 1'b0;
  logic [AW-1:0] retWrData = '0;
  logic [AW-1:0] fetchAddr, decPc, retAddr;
  logic          fetchEn, decValid, running, taskDone, slotErr;

  always #4 clk = ~clk;

  branch_sequencer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .stall(stall), .taskGo(taskGo), .taskVec(taskVec),
    .decOp(decOp), .decCond(decCond), .decTarget(decTarget),
    .flagZ(flagZ), .flagN(flagN), .flagT(flagT),
    .retWrEn(retWrEn), .retWrData(retWrData),
    .fetchAddr(fetchAddr), .fetchEn(fetchEn), .decPc(decPc), .decValid(decValid),
    .retAddr(retAddr), .running(running), .taskDone(taskDone), .slotErr(slotErr)
  );

  // program table, decode fields looked up by the decode-stage address
  logic [2:0]    pOp   [64];
  logic [3:0]    pCond [64];
  logic [AW-1:0] pTgt  [64];
  bit            zDef, nDef, tDef, zBr, nBr, tBr, flipOn;
  logic [AW-1:0] flipAt;

  always_comb begin
    decOp     = decValid ? pOp[decPc[5:0]]   : 3'd0;
    decCond   = decValid ? pCond[decPc[5:0]] : 4'd0;
    decTarget = decValid ? pTgt[decPc[5:0]]  : '0;
    if (flipOn && decValid && decPc == flipAt) {flagZ, flagN, flagT} = {zBr, nBr, tBr};
    else                                       {flagZ, flagN, flagT} = {zDef, nDef, tDef};
  end

  int            checks = 0;
  int            errors = 0;
  int            doneCnt = 0;
  int            errCnt = 0;
  bit            cmpOn = 1'b1;
  bit            stallMode = 1'b0;
  int            modelRpc = 0;
  logic [AW-1:0] expQ [$];
  logic [AW-1:0] expHead;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard pop and compare on every advancing fetch
  always @(negedge clk) begin
    if (rstN) begin
      if (taskDone) doneCnt++;
      if (slotErr)  errCnt++;
      if (cmpOn && fetchEn && !stall) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected fetch addr", fetchAddr, -1);
        end else begin
          expHead = expQ.pop_front();
          chk(fetchAddr == expHead, "R4", "fetch addr", fetchAddr, expHead);
        end
      end
    end
    stall = stallMode ? ($urandom_range(0, 3) == 0) : 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit condOk(int cc, bit z, bit n, bit t);
    case (cc)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return n;
      4: return !n;
      5: return !z && !n;
      6: return z || n;
      7: return t;
      8: return !t;
      default: return 1'b0;
    endcase
  endfunction

  task automatic clearProg();
    for (int a = 0; a < 64; a++) begin
      pOp[a] = 3'd0; pCond[a] = 4'd0; pTgt[a] = '0;
    end
  endtask

  task automatic setIns(input int a, input int op, input int cc, input int tgt);
    pOp[a] = 3'(op); pCond[a] = 4'(cc); pTgt[a] = AW'(tgt);
  endtask

  // driver: expected fetch stream pushed into the scoreboard queue
  task automatic buildExpect(input int vec, input bit z, input bit n, input bit t);
    int pc = vec;
    for (int g = 0; g < 300; g++) begin
      int op = int'(pOp[pc % 64]);
      expQ.push_back(AW'(pc));
      if (op == 4) begin
        for (int d = 1; d <= 6; d++) expQ.push_back(AW'(pc + d));
        break;
      end else if ((op >= 1 && op <= 3) && condOk(int'(pCond[pc % 64]), z, n, t)) begin
        for (int d = 1; d <= 6; d++) expQ.push_back(AW'(pc + d));
        if (op == 2) modelRpc = pc + 4;
        pc = (op == 3) ? modelRpc : int'(pTgt[pc % 64]);
      end else begin
        pc++;
      end
    end
  endtask

  task automatic runTask(input int vec, input bit stallOn, input int expErr,
                         input int midGo, input string req);
    doneCnt = 0; errCnt = 0;
    stallMode = 1'b0;
    repeat (2) @(negedge clk);
    taskVec = AW'(vec); taskGo = 1'b1;
    @(negedge clk);
    taskGo = 1'b0;
    stallMode = stallOn;
    if (midGo > 0) begin
      repeat (midGo) @(negedge clk);
      taskVec = AW'(50); taskGo = 1'b1;
      @(negedge clk);
      taskGo = 1'b0;
    end
    for (int i = 0; i < 3000 && doneCnt == 0; i++) @(negedge clk);
    stallMode = 1'b0;
    repeat (12) @(negedge clk);
    chk(doneCnt == 1, "R7", {req, " done pulses"}, doneCnt, 1);
    chk(running == 1'b0, "R7", {req, " running after stop"}, running, 0);
    chk(errCnt == expErr, "R9", {req, " slot errors"}, errCnt, expErr);
    if (cmpOn) chk(expQ.size() == 0, req, "fetches left unseen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    clearProg();
    {zDef, nDef, tDef} = 3'b000;
    flipOn = 1'b0; flipAt = '0; {zBr, nBr, tBr} = 3'b000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fetchEn == 0,  "R1", "fetchEn",  fetchEn, 0);
    chk(decValid == 0, "R1", "decValid", decValid, 0);
    chk(running == 0,  "R1", "running",  running, 0);
    chk(retAddr == 0,  "R1", "retAddr",  retAddr, 0);
    chk(taskDone == 0 && slotErr == 0, "R1", "pulses", {taskDone, slotErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(fetchEn == 0, "R1", "fetchEn idle after release", fetchEn, 0);

    // R2 / R7: sequential run, debug stop acts as no-op
    clearProg(); setIns(3, 5, 0, 0); setIns(8, 4, 0, 0);
    buildExpect(2, 0, 0, 0);
    runTask(2, 1'b0, 0, 0, "R2");

    // R4 / R8: taken branch with squashed stop in slot four, random stalls
    clearProg(); setIns(10, 1, 0, 30); setIns(14, 4, 0, 0); setIns(33, 4, 0, 0);
    buildExpect(8, 0, 0, 0);
    runTask(8, 1'b1, 0, 0, "R4");
    buildExpect(8, 0, 0, 0);
    runTask(8, 1'b1, 0, 0, "R8");

    // R3 / R10: every condition code against three flag sets
    for (int cc = 0; cc < 10; cc++) begin
      for (int fs = 0; fs < 3; fs++) begin
        clearProg(); setIns(10, 1, cc, 30); setIns(20, 4, 0, 0); setIns(33, 4, 0, 0);
        case (fs)
          0: {zDef, nDef, tDef} = 3'b100;
          1: {zDef, nDef, tDef} = 3'b011;
          default: {zDef, nDef, tDef} = 3'b000;
        endcase
        buildExpect(8, zDef, nDef, tDef);
        runTask(8, 1'b0, 0, 0, "R3");
      end
    end

    // R3: flags sampled while branch sits in decode
    clearProg(); setIns(10, 1, 1, 30); setIns(20, 4, 0, 0); setIns(33, 4, 0, 0);
    flipOn = 1'b1; flipAt = AW'(10);
    {zDef, nDef, tDef} = 3'b000; {zBr, nBr, tBr} = 3'b100;
    buildExpect(8, 1, 0, 0);
    runTask(8, 1'b1, 0, 0, "R3");
    {zDef, nDef, tDef} = 3'b100; {zBr, nBr, tBr} = 3'b000;
    buildExpect(8, 0, 0, 0);
    runTask(8, 1'b1, 0, 0, "R3");
    flipOn = 1'b0;

    // R5 / R10: untaken call, taken call, return
    clearProg();
    {zDef, nDef, tDef} = 3'b100;
    setIns(0, 2, 2, 40); setIns(4, 2, 0, 20); setIns(22, 3, 0, 0); setIns(12, 4, 0, 0);
    buildExpect(0, 1, 0, 0);
    runTask(0, 1'b1, 0, 0, "R5");
    chk(retAddr == 8, "R5", "retAddr after call", retAddr, 8);

    clearProg(); setIns(0, 2, 2, 40); setIns(8, 4, 0, 0);
    buildExpect(0, 1, 0, 0);
    runTask(0, 1'b0, 0, 0, "R10");
    chk(retAddr == 8, "R10", "retAddr after untaken call", retAddr, 8);
    {zDef, nDef, tDef} = 3'b000;

    // R6: restore return register, then return to it
    @(negedge clk); retWrData = AW'(40); retWrEn = 1'b1;
    @(negedge clk); retWrEn = 1'b0;
    @(negedge clk);
    chk(retAddr == 40, "R6", "retAddr after restore", retAddr, 40);
    modelRpc = 40;
    clearProg(); setIns(3, 3, 0, 0); setIns(43, 4, 0, 0);
    buildExpect(1, 0, 0, 0);
    runTask(1, 1'b0, 0, 0, "R6");
    chk(retAddr == 40, "R6", "retAddr held", retAddr, 40);

    // R2: start request while running has no effect
    clearProg(); setIns(40, 4, 0, 0);
    buildExpect(0, 0, 0, 0);
    runTask(0, 1'b0, 0, 10, "R2");

    // R9: slot violations
    cmpOn = 1'b0;
    clearProg(); setIns(10, 1, 1, 30); setIns(12, 2, 1, 30); setIns(20, 4, 0, 0);
    runTask(8, 1'b0, 1, 0, "R9");
    clearProg(); setIns(10, 1, 1, 30); setIns(14, 1, 1, 30); setIns(20, 4, 0, 0);
    runTask(8, 1'b0, 0, 0, "R9");
    clearProg(); setIns(10, 4, 0, 0); setIns(11, 5, 0, 0);
    runTask(8, 1'b1, 1, 0, "R9");
    cmpOn = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule